// File: doc/BRIEF.md
# Dual Configurable Shift Pipeline Register

This block holds sixteen byte-wide stages split into two banks, A and B, of eight stages each. A 2-bit operation code, sampled on every rising clock edge, decides how the stages move. The banks can be chained into one sixteen-stage pipeline, with the last stage of A feeding the first stage of B. Either bank can also be pushed on its own while the other keeps its contents. A fourth code freezes everything.

A 4-bit select input routes any one of the sixteen stages to the byte output through a combinational multiplexer. Reading does not depend on the operation code, so a stage can be read in the same cycle that the banks are being written. An active-low output enable gates the output. When the enable is not asserted, the output is forced to zero and a qualifying flag is cleared, which stands in for a high-impedance pin. A synchronous active-low reset clears every stage.

Top module: `dual_pipe_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all sixteen stages become zero on that edge.
- R2: Operation 2'b00 (chained push) loads `din` into A0, moves A(k) to A(k+1), moves A7 into B0 and B(k) to B(k+1), and drops the old B7. All moves use the values held before the edge.
- R3: Operation 2'b01 (push B) loads `din` into B0 and shifts bank B up by one, dropping the old B7. Bank A is unchanged.
- R4: Operation 2'b10 (push A) loads `din` into A0 and shifts bank A up by one, dropping the old A7. Bank B is unchanged.
- R5: Operation 2'b11 (hold) leaves all sixteen stages unchanged.
- R6: With `oe_n` low, select value s in 0..7 drives stage A(s) on `dout`, and select value s in 8..15 drives stage B(s-8).
- R7: `dout` is combinational from the current stage contents. In a cycle that also shifts, the output shows the value held before the edge, and the new value appears right after that edge.
- R8: With `oe_n` high, `dout` is 8'h00 and `dout_en` is 0. With `oe_n` low, `dout_en` is 1.
- R9: Reset takes priority over every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, clears all stages |
| din | input | 8 | Byte to be loaded into A0 or B0 |
| op | input | 2 | Operation: 00 chained push, 01 push B, 10 push A, 11 hold |
| sel | input | 4 | Stage to read: 0-7 select A0-A7, 8-15 select B0-B7 |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 8 | Selected stage, or zero when disabled |
| dout_en | output | 1 | High when `dout` carries valid data |

## Verification
A stage that captured a wrong value stays hidden until the select input points at it. The bench therefore reads every stage after each phase of a sequence, not only the stage that was just written. A wrong shift or a missed cascade shows one cycle after the faulty edge, in the stage that should have received the byte. A lost hold shows as a change at a stage that should have stayed stable. Stimulus is applied mid-cycle and read before the next edge, so an output that wrongly depends on the clock is seen in the same cycle.

// File: rtl/dpr_pkg.sv
// Package: shared operation encoding for the dual pipeline register.
// Assumes a 2-bit operation field, sampled once per rising clock edge.
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_CHAIN  = 2'b00,
        OP_PUSH_B = 2'b01,
        OP_PUSH_A = 2'b10,
        OP_HOLD   = 2'b11
    } dpr_op_e;

endpackage

// File: rtl/dpr_ctrl.sv
// Module: dpr_ctrl
// Decodes the operation code into one shift enable per bank.
// Also picks what bank B receives: the last A stage when chained, the input byte otherwise.
// Assumes the operation code is stable around the clock edge.
module dpr_ctrl
    import dpr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  dpr_op_e          op,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] a_last,
    output logic             a_shift,
    output logic             b_shift,
    output logic [WIDTH-1:0] b_feed
);

    // Purpose: turn the operation into bank enables and the B source.
    always_comb begin
        a_shift = 1'b0;
        b_shift = 1'b0;
        b_feed  = din;
        unique case (op)
            OP_CHAIN: begin
                a_shift = 1'b1;
                b_shift = 1'b1;
                b_feed  = a_last;
            end
            OP_PUSH_B: b_shift = 1'b1;
            OP_PUSH_A: a_shift = 1'b1;
            default: ; // OP_HOLD: no bank moves
        endcase
    end

endmodule

// File: rtl/dpr_bank.sv
// Module: dpr_bank
// A bank of DEPTH registers, each WIDTH bits wide.
// When shift_en is high, stage 0 takes shift_in and every other stage takes the one below it.
// Assumes DEPTH >= 2. Reset is synchronous and active low.
module dpr_bank #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [WIDTH-1:0]            shift_in,
    output logic [DEPTH-1:0][WIDTH-1:0] stages
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    // Purpose: stage 0 register, captures the incoming byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q[0] <= '0;
        else if (shift_en) stage_q[0] <= shift_in;
    end

    // Purpose: one register per upper stage, each taking its lower neighbour.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)        stage_q[g] <= '0;
            else if (shift_en) stage_q[g] <= stage_q[g-1];
        end
    end

    // Purpose: pack the stages for the readers.
    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
        assign stages[g] = stage_q[g];
    end

    // R1: a reset edge leaves the bank empty
    a_r1_bank_cleared: assert property (@(posedge clk)
        !rst_n |=> (stages == '0));

    // R5: a bank that is not enabled keeps every stage
    a_r5_bank_still: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stages));

    // R4: an enabled bank captures the input byte in stage 0
    a_r4_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (stages[0] == $past(shift_in)));

    // R2: an enabled bank moves its second-to-last stage into its last stage
    a_r2_bank_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (stages[DEPTH-1] == $past(stages[DEPTH-2])));

endmodule

// File: rtl/dpr_outmux.sv
// Module: dpr_outmux
// Routes one of the 2*DEPTH stages to the output.
// Indices below DEPTH read bank A and the rest read bank B.
// Assumes DEPTH is a power of two, so every select value names a stage.
module dpr_outmux #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int SEL_W = $clog2(2 * DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] bank_a,
    input  logic [DEPTH-1:0][WIDTH-1:0] bank_b,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        oe_n,
    output logic [WIDTH-1:0]            dout,
    output logic                        dout_en
);

    localparam int TOTAL = 2 * DEPTH;

    logic [WIDTH-1:0] flat [TOTAL];

    // Purpose: lay both banks out in one index space, A first.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g]         = bank_a[g];
        assign flat[g + DEPTH] = bank_b[g];
    end

    // Purpose: select the addressed stage and gate it with the enable.
    always_comb begin
        dout_en = !oe_n;
        dout    = oe_n ? '0 : flat[sel];
    end

endmodule

// File: rtl/dual_pipe_reg.sv
// Module: dual_pipe_reg (top)
// Sixteen-stage byte pipeline built from two banks that can be chained or pushed alone.
// Any stage can be read at any time through a combinational select.
// Assumes a synchronous active-low reset and an active-low output enable.
module dual_pipe_reg
    import dpr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int SEL_W = $clog2(2 * DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] sel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en
);

    dpr_op_e                    op_e;
    logic                       a_shift;
    logic                       b_shift;
    logic [WIDTH-1:0]           b_feed;
    logic [DEPTH-1:0][WIDTH-1:0] a_q;
    logic [DEPTH-1:0][WIDTH-1:0] b_q;

    // Purpose: give the raw operation bits their enumerated meaning.
    assign op_e = dpr_op_e'(op);

    dpr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .op      (op_e),
        .din     (din),
        .a_last  (a_q[DEPTH-1]),
        .a_shift (a_shift),
        .b_shift (b_shift),
        .b_feed  (b_feed)
    );

    dpr_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (a_shift),
        .shift_in (din),
        .stages   (a_q)
    );

    dpr_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (b_shift),
        .shift_in (b_feed),
        .stages   (b_q)
    );

    dpr_outmux #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_outmux (
        .bank_a  (a_q),
        .bank_b  (b_q),
        .sel     (sel),
        .oe_n    (oe_n),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R2: a chained push hands the old last A stage to B0
    a_r2_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00) |=> (b_q[0] == $past(a_q[DEPTH-1])));

    // R2: a chained push loads the input byte into A0
    a_r2_chain_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00) |=> (a_q[0] == $past(din)));

    // R3: pushing B leaves bank A untouched
    a_r3_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01) |=> $stable(a_q));

    // R3: pushing B loads the input byte into B0
    a_r3_b_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01) |=> (b_q[0] == $past(din)));

    // R4: pushing A leaves bank B untouched
    a_r4_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10) |=> $stable(b_q));

    // R5: hold freezes both banks
    a_r5_hold_all: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11) |=> ($stable(a_q) && $stable(b_q)));

    // R7: with hold, a steady select and the enable kept on, the output stays put
    a_r7_steady_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 2'b11) && !oe_n) |=> (!oe_n && $stable(sel)) |-> $stable(dout));

endmodule

// File: tb/dual_pipe_reg_tb.sv
module dual_pipe_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;
    localparam int WATCHDOG   = 5000;

    // Vector fields: op[14:13] din[12:5] sel[4:1] oe_n[0]
    localparam logic [14:0] VEC [NVEC] = '{
        {2'b10, 8'h11, 4'd0,  1'b0},
        {2'b10, 8'h22, 4'd0,  1'b0},
        {2'b10, 8'h33, 4'd1,  1'b0},
        {2'b01, 8'h44, 4'd8,  1'b0},
        {2'b01, 8'h55, 4'd8,  1'b0},
        {2'b11, 8'h99, 4'd9,  1'b0},
        {2'b00, 8'h66, 4'd2,  1'b0},
        {2'b00, 8'h77, 4'd0,  1'b1},
        {2'b10, 8'h88, 4'd3,  1'b0},
        {2'b10, 8'h99, 4'd10, 1'b0},
        {2'b10, 8'hAA, 4'd4,  1'b0},
        {2'b10, 8'hBB, 4'd7,  1'b0},
        {2'b10, 8'hCC, 4'd7,  1'b0},
        {2'b00, 8'hDD, 4'd7,  1'b0},
        {2'b00, 8'hEE, 4'd8,  1'b0},
        {2'b11, 8'h00, 4'd15, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic [1:0] op = 2'b11;
    logic [3:0] sel = '0;
    logic       oe_n = 1'b0;
    logic [7:0] dout;
    logic       dout_en;

    logic [7:0] ref_a [8];
    logic [7:0] ref_b [8];
    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    dual_pipe_reg u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .op      (op),
        .sel     (sel),
        .oe_n    (oe_n),
        .dout    (dout),
        .dout_en (dout_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: counts cycles and fails the run if it hangs
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fails  = n_fails + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: cycles %0d expected < %0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp,
                         logic got_en, logic exp_en);
        n_checks++;
        if (got !== exp || got_en !== exp_en) begin
            n_fails++;
            $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b",
                     tag, got, got_en, exp, exp_en);
        end
    endtask

    function automatic logic [7:0] model_read(logic [3:0] s);
        return (s < 8) ? ref_a[s[2:0]] : ref_b[s[2:0]];
    endfunction

    // Reference update from the requirements, using pre-edge values
    task automatic model_step(logic [1:0] o, logic [7:0] d);
        logic [7:0] oa [8];
        logic [7:0] ob [8];
        oa = ref_a;
        ob = ref_b;
        if (o == 2'b00 || o == 2'b10) begin
            ref_a[0] = d;
            for (int k = 1; k < 8; k++) ref_a[k] = oa[k-1];
        end
        if (o == 2'b00 || o == 2'b01) begin
            ref_b[0] = (o == 2'b00) ? oa[7] : d;
            for (int k = 1; k < 8; k++) ref_b[k] = ob[k-1];
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 8; k++) begin
            ref_a[k] = '0;
            ref_b[k] = '0;
        end
    endtask

    // Drives one operation mid-cycle, checks the pre-edge read, then clocks it
    task automatic apply(string tag, logic [1:0] o, logic [7:0] d,
                         logic [3:0] s, logic oen);
        @(negedge clk);
        op = o; din = d; sel = s; oe_n = oen;
        #1;
        check(tag, dout, oen ? 8'h00 : model_read(s), dout_en, !oen);
        @(posedge clk);
        model_step(o, d);
    endtask

    // Reads every stage under hold and compares with the model
    task automatic sweep(string tag);
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            op = 2'b11; sel = 4'(s); oe_n = 1'b0;
            #1;
            check(tag, dout, model_read(4'(s)), dout_en, 1'b1);
        end
    endtask

    initial begin
        model_clear();
        rst_n = 1'b0;
        op = 2'b00; din = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op = 2'b11;

        // R1: all stages read zero after reset
        sweep("R1 reset state");

        // Table walk: tags follow the operation code
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] vo;
            vo = VEC[i][14:13];
            apply(vo == 2'b00 ? "R2 chained push" :
                  vo == 2'b01 ? "R3 push B" :
                  vo == 2'b10 ? "R4 push A" : "R5 hold",
                  vo, VEC[i][12:5], VEC[i][4:1], VEC[i][0]);
        end
        // R6: the whole state matches after the table
        sweep("R6 select map");

        // R7: a read during a push shows the old value, then the new one
        @(negedge clk);
        op = 2'b10; din = 8'h5A; sel = 4'd0; oe_n = 1'b0;
        #1;
        check("R7 pre-edge read", dout, model_read(4'd0), dout_en, 1'b1);
        @(posedge clk);
        model_step(2'b10, 8'h5A);
        #1;
        check("R7 post-edge read", dout, 8'h5A, dout_en, 1'b1);

        // R8: a disabled output is zero with the flag low, state untouched
        @(negedge clk);
        op = 2'b11; sel = 4'd0; oe_n = 1'b1;
        #1;
        check("R8 disabled", dout, 8'h00, dout_en, 1'b0);
        oe_n = 1'b0;
        #1;
        check("R8 re-enabled", dout, 8'h5A, dout_en, 1'b1);

        // R3: pushes into B push the old B7 out while A stays put
        for (int k = 0; k < 8; k++) apply("R3 fill B", 2'b01, 8'(8'hC0 + k), 4'd15, 1'b0);
        sweep("R3 after B fill");

        // R2: a chained run carries A into B
        for (int k = 0; k < 9; k++) apply("R2 chain run", 2'b00, 8'(8'h30 + k), 4'd7, 1'b0);
        sweep("R2 after chain");

        // R9: reset wins over a chained push
        @(negedge clk);
        rst_n = 1'b0; op = 2'b00; din = 8'hFF;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1; op = 2'b11;
        sweep("R9 reset priority");

        done = 1'b1;
        summary();
    end

endmodule